// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block turns a virtual address into a physical address by reading a tree of translation tables that sit in ordinary memory. A root address input gives the location of the top table. The virtual page number is cut into equal index fields, one per level, with the most significant field used first. Each fetched entry either names the frame that holds the next table or, at the last level, names the physical frame of the page. The page offset is copied straight into the low bits of the result.

A requester presents a virtual address while `req_ready` is high. The walker then issues one memory read per level over a request/grant port, waits for each read to return (any latency), and ends with a single-cycle `rsp_done` pulse that carries either the physical address or a fault, the kind of fault, and the level where the walk stopped. One walk is in flight at a time. Caching of translations, fault service and page replacement belong to other blocks.

Top module: `mlpt_walker`

## Requirements
- R1: While reset is asserted, `req_ready` is 1, `rsp_done` is 0 and `mem_rd_req` is 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1; `req_ready` is 0 from the cycle after acceptance until the cycle of `rsp_done`, and a `req_valid` pulse during that time changes neither the result nor the number of reads.
- R3: The first read of a walk uses address `root + 4 * idx0` modulo 2^PA_W, where idx0 is the most significant IDX_W bits of the virtual page number and `root` is sampled in the accepting cycle.
- R4: The read for level k > 0 uses address `(F << OFS_W) + 4 * idxk` modulo 2^PA_W, where F is the frame field (entry bits [31:16] for the default sizes, the top PPN_W bits in general) of the level k-1 entry and idxk is the k-th index field counted from the top.
- R5: Once `mem_rd_req` is raised it stays high with an unchanged `mem_rd_addr` until the cycle in which `mem_rd_gnt` is 1.
- R6: After a walk whose entries are all valid, `rsp_pa` equals the last entry's frame field followed by the virtual address's low OFS_W bits, unchanged, and `rsp_fault` is 0.
- R7: An entry that is all zeros ends the walk at once with `rsp_fault`=1, `rsp_fault_null`=1, `rsp_pa`=0 and `rsp_level` equal to the level (0 = top) of that entry.
- R8: A nonzero entry whose bit 0 (the present bit) is 0 ends the walk at once with `rsp_fault`=1, `rsp_fault_null`=0, `rsp_pa`=0 and `rsp_level` equal to that entry's level.
- R9: `rsp_done` is high for exactly one cycle, the cycle after the one in which the deciding read data was accepted, and `req_ready` is 1 in that cycle.
- R10: A walk makes exactly one read per level reached (LEVELS reads without a fault, k+1 reads for a fault at level k), never more than one read outstanding, and no read after its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| root | input | PA_W | Byte address of the top-level table, sampled on acceptance |
| req_valid | input | 1 | Translation request present |
| req_va | input | VA_W | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to take a request |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_pa | output | PA_W | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Walk ended on a missing entry |
| rsp_fault_null | output | 1 | The missing entry was all zeros |
| rsp_level | output | LVL_W | Level of the entry that ended the walk |
| mem_rd_req | output | 1 | Entry read request |
| mem_rd_addr | output | PA_W | Byte address of the entry |
| mem_rd_gnt | input | 1 | Memory takes the read this cycle |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | PTE_W | Fetched table entry |

## Verification
The first read request appears the cycle after acceptance, each later read appears the cycle after the previous data returns, and `rsp_done` is due exactly one cycle after the final data beat, whatever grant and latency pattern the memory uses. The bench drives and samples on the falling edge, checks each read address at the moment it is granted against its own walk of the same tables, and stamps the cycle of every data beat so that the result strobe can be required in the very next cycle rather than merely within a window. Grant gaps and read latencies of zero to two cycles rotate across walks, so every timing relation is checked under several delays.

// File: rtl/mlpt_pkg.sv
package mlpt_pkg;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ISSUE = 2'd1,
    WK_WAIT  = 2'd2
  } walk_state_e;

  // entries are four bytes wide, so an index is scaled by 2^2
  localparam int unsigned PTE_BYTES_LOG2 = 2;
  // position of the present flag inside an entry
  localparam int unsigned PTE_PRESENT_POS = 0;

endpackage

// File: rtl/mlpt_idx_sel.sv
module mlpt_idx_sel #(
  parameter int unsigned VPN_W  = 24,
  parameter int unsigned LEVELS = 3,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned LVL_W  = 2
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] fields [LEVELS];

  // level 0 takes the most significant field
  for (genvar g = 0; g < LEVELS; g++) begin : g_field
    assign fields[g] = vpn[VPN_W-1-g*IDX_W -: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int unsigned s = 0; s < LEVELS; s++) begin
      if (level == LVL_W'(s)) idx = fields[s];
    end
  end

endmodule

// File: rtl/mlpt_pte_dec.sv
module mlpt_pte_dec
  import mlpt_pkg::*;
#(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned PPN_W = 16
) (
  input  logic [PTE_W-1:0] pte,
  output logic             present,
  output logic             is_null,
  output logic [PPN_W-1:0] ppn
);

  assign present = pte[PTE_PRESENT_POS];
  assign is_null = (pte == '0);
  // the frame number sits in the top bits of the entry
  assign ppn     = pte[PTE_W-1 -: PPN_W];

endmodule

// File: rtl/mlpt_addr_gen.sv
module mlpt_addr_gen
  import mlpt_pkg::*;
#(
  parameter int unsigned PA_W  = 24,
  parameter int unsigned OFS_W = 8,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned PPN_W = PA_W - OFS_W
) (
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [IDX_W-1:0] idx,
  input  logic [PPN_W-1:0] ppn,
  input  logic [OFS_W-1:0] ofs,
  output logic [PA_W-1:0]  entry_addr,
  output logic [PA_W-1:0]  next_base,
  output logic [PA_W-1:0]  leaf_pa
);

  // byte address of one entry: base plus scaled index, wrapping at PA_W
  function automatic logic [PA_W-1:0] f_entry_addr(input logic [PA_W-1:0] b,
                                                   input logic [IDX_W-1:0] i);
    logic [PA_W-1:0] scaled;
    scaled = '0;
    scaled[IDX_W+PTE_BYTES_LOG2-1:0] = {i, {PTE_BYTES_LOG2{1'b0}}};
    return b + scaled;
  endfunction

  // a frame number names the first byte of that frame
  function automatic logic [PA_W-1:0] f_frame_base(input logic [PPN_W-1:0] p);
    return {p, {OFS_W{1'b0}}};
  endfunction

  // frame number joined with the untouched page offset
  function automatic logic [PA_W-1:0] f_join(input logic [PPN_W-1:0] p,
                                             input logic [OFS_W-1:0] o);
    return {p, o};
  endfunction

  assign entry_addr = f_entry_addr(tbl_base, idx);
  assign next_base  = f_frame_base(ppn);
  assign leaf_pa    = f_join(ppn, ofs);

endmodule

// File: rtl/mlpt_walk_ctl.sv
module mlpt_walk_ctl
  import mlpt_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 24,
  parameter int unsigned LEVELS = 3,
  parameter int unsigned LVL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic [PA_W-1:0]  root,
  input  logic             mem_rd_gnt,
  input  logic             mem_rd_valid,
  input  logic             pte_present,
  input  logic             pte_null,
  input  logic [PA_W-1:0]  next_base,
  input  logic [PA_W-1:0]  leaf_pa,
  output logic             req_ready,
  output logic             mem_rd_req,
  output logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  tbl_base,
  output logic [VA_W-1:0]  va_q,
  output logic             rsp_done,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_fault,
  output logic             rsp_fault_null,
  output logic [LVL_W-1:0] rsp_level
);

  walk_state_e state;
  logic        last_level;
  logic        data_in;

  assign req_ready  = (state == WK_IDLE);
  assign mem_rd_req = (state == WK_ISSUE);
  assign data_in    = (state == WK_WAIT) && mem_rd_valid;
  assign last_level = (level == LVL_W'(LEVELS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= WK_IDLE;
      level          <= '0;
      tbl_base       <= '0;
      va_q           <= '0;
      rsp_done       <= 1'b0;
      rsp_pa         <= '0;
      rsp_fault      <= 1'b0;
      rsp_fault_null <= 1'b0;
      rsp_level      <= '0;
    end else begin
      rsp_done <= 1'b0;
      unique case (state)
        WK_IDLE: begin
          if (req_valid) begin
            va_q     <= req_va;
            tbl_base <= root;
            level    <= '0;
            state    <= WK_ISSUE;
          end
        end
        WK_ISSUE: begin
          if (mem_rd_gnt) state <= WK_WAIT;
        end
        WK_WAIT: begin
          if (data_in) begin
            if (!pte_present) begin
              rsp_done       <= 1'b1;
              rsp_fault      <= 1'b1;
              rsp_fault_null <= pte_null;
              rsp_pa         <= '0;
              rsp_level      <= level;
              state          <= WK_IDLE;
            end else if (last_level) begin
              rsp_done       <= 1'b1;
              rsp_fault      <= 1'b0;
              rsp_fault_null <= 1'b0;
              rsp_pa         <= leaf_pa;
              rsp_level      <= level;
              state          <= WK_IDLE;
            end else begin
              tbl_base <= next_base;
              level    <= level + LVL_W'(1);
              state    <= WK_ISSUE;
            end
          end
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mlpt_walker.sv
module mlpt_walker #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 24,
  parameter int unsigned OFS_W  = 8,
  parameter int unsigned LEVELS = 3,
  parameter int unsigned PTE_W  = 32,
  localparam int unsigned VPN_W = VA_W - OFS_W,
  localparam int unsigned IDX_W = VPN_W / LEVELS,
  localparam int unsigned PPN_W = PA_W - OFS_W,
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  root,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  output logic             req_ready,
  output logic             rsp_done,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_fault,
  output logic             rsp_fault_null,
  output logic [LVL_W-1:0] rsp_level,
  output logic             mem_rd_req,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_gnt,
  input  logic             mem_rd_valid,
  input  logic [PTE_W-1:0] mem_rd_data
);

  logic [LVL_W-1:0] level;
  logic [PA_W-1:0]  tbl_base;
  logic [VA_W-1:0]  va_q;
  logic [IDX_W-1:0] cur_idx;
  logic             pte_present;
  logic             pte_null;
  logic [PPN_W-1:0] pte_ppn;
  logic [PA_W-1:0]  next_base;
  logic [PA_W-1:0]  leaf_pa;

  // named events for the checker
  logic ev_accept;
  logic ev_grant;
  assign ev_accept = req_valid && req_ready;
  assign ev_grant  = mem_rd_req && mem_rd_gnt;

  mlpt_idx_sel #(
    .VPN_W (VPN_W),
    .LEVELS(LEVELS),
    .IDX_W (IDX_W),
    .LVL_W (LVL_W)
  ) u_idx (
    .vpn  (va_q[VA_W-1:OFS_W]),
    .level(level),
    .idx  (cur_idx)
  );

  mlpt_pte_dec #(
    .PTE_W(PTE_W),
    .PPN_W(PPN_W)
  ) u_dec (
    .pte    (mem_rd_data),
    .present(pte_present),
    .is_null(pte_null),
    .ppn    (pte_ppn)
  );

  mlpt_addr_gen #(
    .PA_W (PA_W),
    .OFS_W(OFS_W),
    .IDX_W(IDX_W),
    .PPN_W(PPN_W)
  ) u_addr (
    .tbl_base  (tbl_base),
    .idx       (cur_idx),
    .ppn       (pte_ppn),
    .ofs       (va_q[OFS_W-1:0]),
    .entry_addr(mem_rd_addr),
    .next_base (next_base),
    .leaf_pa   (leaf_pa)
  );

  mlpt_walk_ctl #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .LEVELS(LEVELS),
    .LVL_W (LVL_W)
  ) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_va        (req_va),
    .root          (root),
    .mem_rd_gnt    (mem_rd_gnt),
    .mem_rd_valid  (mem_rd_valid),
    .pte_present   (pte_present),
    .pte_null      (pte_null),
    .next_base     (next_base),
    .leaf_pa       (leaf_pa),
    .req_ready     (req_ready),
    .mem_rd_req    (mem_rd_req),
    .level         (level),
    .tbl_base      (tbl_base),
    .va_q          (va_q),
    .rsp_done      (rsp_done),
    .rsp_pa        (rsp_pa),
    .rsp_fault     (rsp_fault),
    .rsp_fault_null(rsp_fault_null),
    .rsp_level     (rsp_level)
  );

endmodule

// File: rtl/mlpt_walker_chk.sv
module mlpt_walker_chk #(
  parameter int unsigned PA_W   = 24,
  parameter int unsigned OFS_W  = 8,
  parameter int unsigned LEVELS = 3,
  parameter int unsigned LVL_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OFS_W-1:0] req_ofs,
  input logic             req_ready,
  input logic             rsp_done,
  input logic [PA_W-1:0]  rsp_pa,
  input logic             rsp_fault,
  input logic             rsp_fault_null,
  input logic [LVL_W-1:0] rsp_level,
  input logic             mem_rd_req,
  input logic [PA_W-1:0]  mem_rd_addr,
  input logic             mem_rd_gnt,
  input logic             mem_rd_valid,
  input logic             ev_accept,
  input logic             ev_grant
);

  logic [1:0]       rd_open;
  logic [OFS_W-1:0] ofs_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_open <= '0;
      ofs_cap <= '0;
    end else begin
      if (ev_accept) ofs_cap <= req_ofs;
      if (ev_grant && !mem_rd_valid) rd_open <= rd_open + 2'd1;
      else if (!ev_grant && mem_rd_valid && rd_open != 2'd0) rd_open <= rd_open - 2'd1;
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready && !rsp_done);

  p_read_follows_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> mem_rd_req);

  p_hold_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_gnt |=> mem_rd_req && $stable(mem_rd_addr));

  p_offset_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && !rsp_fault |-> rsp_pa[OFS_W-1:0] == ofs_cap);

  p_fault_zero_pa_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_fault |-> rsp_pa == '0);

  p_null_is_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_fault_null |-> rsp_fault);

  p_level_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> rsp_level < LVL_W'(LEVELS));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_done_after_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(mem_rd_valid) && req_ready);

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grant |-> rd_open == 2'd0);

  p_data_matches_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> rd_open == 2'd1);

endmodule

bind mlpt_walker mlpt_walker_chk #(
  .PA_W  (PA_W),
  .OFS_W (OFS_W),
  .LEVELS(LEVELS),
  .LVL_W (LVL_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ofs       (req_va[OFS_W-1:0]),
  .req_ready     (req_ready),
  .rsp_done      (rsp_done),
  .rsp_pa        (rsp_pa),
  .rsp_fault     (rsp_fault),
  .rsp_fault_null(rsp_fault_null),
  .rsp_level     (rsp_level),
  .mem_rd_req    (mem_rd_req),
  .mem_rd_addr   (mem_rd_addr),
  .mem_rd_gnt    (mem_rd_gnt),
  .mem_rd_valid  (mem_rd_valid),
  .ev_accept     (ev_accept),
  .ev_grant      (ev_grant)
);

// File: tb/mlpt_walker_bench.sv
module mlpt_walker_bench;

  localparam int VA_W = 32;
  localparam int PA_W = 24;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PA_W-1:0] root = '0;
  logic            req_valid = 1'b0;
  logic [VA_W-1:0] req_va = '0;
  logic            req_ready;
  logic            rsp_done;
  logic [PA_W-1:0] rsp_pa;
  logic            rsp_fault;
  logic            rsp_fault_null;
  logic [1:0]      rsp_level;
  logic            mem_rd_req;
  logic [PA_W-1:0] mem_rd_addr;
  logic            mem_rd_gnt = 1'b0;
  logic            mem_rd_valid = 1'b0;
  logic [31:0]     mem_rd_data = '0;

  always #5 clk = ~clk;

  mlpt_walker u_mlpt_walker (
    .clk(clk), .rst_n(rst_n), .root(root), .req_valid(req_valid), .req_va(req_va),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_fault_null(rsp_fault_null), .rsp_level(rsp_level), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_gnt(mem_rd_gnt), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // table contents are a function of the entry address and its level
  function automatic logic [15:0] frame_of(input logic [PA_W-1:0] a, input int k);
    logic [7:0] kk = 8'(k);
    return a[17:2] ^ 16'h3C5A ^ {kk, kk};
  endfunction
  function automatic logic [31:0] ent_good(input logic [PA_W-1:0] a, input int k);
    return {frame_of(a, k), 15'h2A6B, 1'b1};
  endfunction
  function automatic logic [31:0] ent_bad(input logic [PA_W-1:0] a, input int k, input bit nul);
    return nul ? 32'h0 : {frame_of(a, k), 15'h0101, 1'b0};
  endfunction

  // expectations of the current walk
  logic [PA_W-1:0] e_addr [3];
  int              e_reads;
  bit              e_fault, e_null;
  int              e_lvl;
  logic [PA_W-1:0] e_pa;
  int              inj_k = -1;
  bit              inj_null = 1'b0;

  // memory model state
  int              rd_n = 0, rd_total = 0, gcnt = 0, lat_left = 0, last_rsp_cyc = -10;
  bit              pend = 1'b0, done_seen = 1'b0, prev_done = 1'b0;
  logic [31:0]     pdata;
  logic [PA_W-1:0] g_pa;
  bit              g_fault, g_null;
  logic [1:0]      g_lvl;
  int              g_reads;

  task automatic plan(input logic [VA_W-1:0] va, input logic [PA_W-1:0] rt,
                      input int ik, input bit inul);
    logic [PA_W-1:0] base = rt;
    logic [31:0]     w;
    inj_k = ik; inj_null = inul;
    e_reads = 0; e_fault = 0; e_null = 0; e_lvl = 0; e_pa = '0;
    for (int k = 0; k < 3; k++) begin
      logic [7:0] ix = va[31-8*k -: 8];
      e_addr[k] = base + PA_W'(ix) * 4;
      e_reads++;
      if (k == ik) begin
        e_fault = 1; e_null = inul; e_lvl = k; e_pa = '0;
        break;
      end
      w = ent_good(e_addr[k], k);
      base = PA_W'(w[31:16]) * 256;
      if (k == 2) begin
        e_lvl = 2;
        e_pa = PA_W'(w[31:16]) * 256 + PA_W'(va[7:0]);
      end
    end
  endtask

  // memory responder and result monitor, all on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rsp_done) begin
          done_seen = 1; g_pa = rsp_pa; g_fault = rsp_fault; g_null = rsp_fault_null;
          g_lvl = rsp_level; g_reads = rd_n;
          chk(cyc == last_rsp_cyc + 1, "R9", "done one cycle after data", 32'(cyc), 32'(last_rsp_cyc + 1));
          chk(req_ready == 1'b1, "R9", "ready with done", 32'(req_ready), 32'd1);
          if (prev_done) chk(1'b0, "R9", "done longer than one cycle", 32'd1, 32'd0);
        end
        prev_done = rsp_done;
      end
      mem_rd_valid = 1'b0;
      if (pend) begin
        if (lat_left == 0) begin
          mem_rd_valid = 1'b1; mem_rd_data = pdata; pend = 0; last_rsp_cyc = cyc;
        end else lat_left--;
      end
      mem_rd_gnt = (gcnt % 3) != 0;
      gcnt++;
      if (rst_n && mem_rd_req && mem_rd_gnt && !pend && !mem_rd_valid) begin
        if (rd_n >= e_reads) begin
          chk(1'b0, "R10", "read beyond walk", 32'(rd_n + 1), 32'(e_reads));
          pdata = 32'h0;
        end else begin
          if (rd_n == 0) chk(mem_rd_addr == e_addr[0], "R3", "top entry address", 32'(mem_rd_addr), 32'(e_addr[0]));
          else chk(mem_rd_addr == e_addr[rd_n], "R4", "lower entry address", 32'(mem_rd_addr), 32'(e_addr[rd_n]));
          pdata = (rd_n == inj_k) ? ent_bad(mem_rd_addr, rd_n, inj_null) : ent_good(mem_rd_addr, rd_n);
        end
        pend = 1; lat_left = rd_total % 3; rd_n++; rd_total++;
      end
    end
  end

  task automatic wait_done();
    int t = 0;
    while (!done_seen && t < 200) begin
      @(negedge clk); t++;
    end
    if (!done_seen) chk(1'b0, "R9", "walk never finished", 32'(t), 32'd0);
  endtask

  task automatic check_result(input logic [VA_W-1:0] va);
    chk(g_fault == e_fault, e_fault ? (e_null ? "R7" : "R8") : "R6", "fault flag", 32'(g_fault), 32'(e_fault));
    chk(g_pa == e_pa, e_fault ? "R7" : "R6", "physical address", 32'(g_pa), 32'(e_pa));
    if (e_fault) begin
      chk(g_null == e_null, e_null ? "R7" : "R8", "null kind", 32'(g_null), 32'(e_null));
      chk(32'(g_lvl) == 32'(e_lvl), e_null ? "R7" : "R8", "stop level", 32'(g_lvl), 32'(e_lvl));
    end
    chk(g_reads == e_reads, "R10", "reads per walk", 32'(g_reads), 32'(e_reads));
    if (!e_fault) chk(g_pa[7:0] == va[7:0], "R6", "offset unchanged", 32'(g_pa[7:0]), 32'(va[7:0]));
  endtask

  task automatic walk(input logic [VA_W-1:0] va, input logic [PA_W-1:0] rt,
                      input int ik, input bit inul);
    plan(va, rt, ik, inul);
    rd_n = 0; done_seen = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_va = va; root = rt;
    @(negedge clk);
    req_valid = 1'b0; root = ~rt;
    wait_done();
    check_result(va);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 32'(cyc), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    e_reads = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 32'd1);
    chk(rsp_done == 1'b0, "R1", "done in reset", 32'(rsp_done), 32'd0);
    chk(mem_rd_req == 1'b0, "R1", "read request in reset", 32'(mem_rd_req), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // sweep each index field in turn over all its values
    for (int i = 0; i < 256; i++)
      walk({8'(i), 8'h37, 8'hC4, 8'(i ^ 8'h5A)}, 24'h040000, -1, 1'b0);
    for (int i = 0; i < 256; i++)
      walk({8'h91, 8'(i), 8'h0E, 8'(255 - i)}, 24'h13A400, -1, 1'b0);
    for (int i = 0; i < 256; i++)
      walk({8'h2B, 8'hE0, 8'(i), 8'(i * 7)}, 24'hFFFC00, -1, 1'b0);

    // faults at every level, both kinds, several addresses
    for (int k = 0; k < 3; k++)
      for (int n = 0; n < 2; n++)
        for (int j = 0; j < 8; j++)
          walk(32'h1357_9BDF ^ (32'(j) * 32'h0101_0103), 24'h00C000 + 24'(j) * 24'h400, k, n[0]);

    // R2: a request pulse while busy must not disturb the walk
    begin
      logic [VA_W-1:0] va_a = 32'hA5C3_7E19;
      plan(va_a, 24'h220000, -1, 1'b0);
      rd_n = 0; done_seen = 0;
      @(negedge clk);
      req_valid = 1'b1; req_va = va_a; root = 24'h220000;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(req_ready == 1'b0, "R2", "busy during walk", 32'(req_ready), 32'd0);
      req_valid = 1'b1; req_va = 32'h0F0F_0F0F; root = 24'h777700;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done();
      check_result(va_a);
      for (int t = 0; t < 5; t++) begin
        @(negedge clk);
        chk(mem_rd_req == 1'b0, "R2", "no read after ignored request", 32'(mem_rd_req), 32'd0);
        chk(rsp_done == 1'b0, "R2", "no second result", 32'(rsp_done), 32'd0);
      end
    end

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule